// File: doc/BRIEF.md
# Pin Bank Controller with Atomic Set/Clear Access

This block controls a bank of general-purpose pins through a small memory-mapped register bus. For each pin it holds an output level, a direction bit, a pull-disable bit and a two-bit function selector. Software changes the output level and the direction of single pins without a read-modify-write sequence. It writes a mask to a dedicated "set" or "clear" address, and only the pins whose mask bit is 1 change. The full registers can also be written directly.

Each pin drives a data/enable pair toward its pad. When a pin's function selector is zero, the pair comes from the pin's own registers. When the selector is non-zero, one of three external peripherals drives the pair. Pin inputs pass through a two-stage synchronizer before software reads them. The bus read path is combinational on the address, so read data is valid in the same cycle as the address.

Top module: `pinbank_gpio`

## Requirements
- R1: After a synchronous active-low reset, every register holds 0. Every pin is then an input (`pin_oe` = 0) in function 0, with `pin_out` = 0 and `pull_dis` = 0, and every mapped address reads 0.
- R2: A write to offset 0x04 sets each output-data bit whose write-data bit is 1 and leaves the other bits unchanged. The change appears after the write's clock edge.
- R3: A write to offset 0x08 clears each output-data bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: A write to offset 0x14 sets, and a write to offset 0x18 clears, the masked direction bits. A direction bit of 1 makes the pin an output, so `pin_oe` of a function-0 pin equals its direction bit.
- R5: A write to offset 0x00 loads the whole output-data register. A write to offset 0x10 loads the whole direction register.
- R6: A read of offset 0x00 returns, per bit, the stored output value for output pins. For input pins it returns the pad level seen through two flip-flops, so a new pad level first shows on a read after the second rising edge that samples it.
- R7: A pin's function number is {bit at 0x24, bit at 0x20}. Value 0 drives `pin_out`/`pin_oe` from the output-data and direction bits. Values 1, 2 and 3 drive them from peripheral 0, 1 and 2 of `alt_dout`/`alt_oe`.
- R8: Offsets 0x10, 0x20 and 0x24 read back their stored values. Offsets 0x04, 0x08, 0x14 and 0x18 read as 0. Any unmapped offset reads 0, and a write to it changes no register.
- R9: Offset 0x0C is a plain read/write pull-disable register, and its contents drive `pull_dis`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 6 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data / set-clear mask |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | 32 | Asynchronous pad input levels |
| pin_out | output | 32 | Pad output data |
| pin_oe | output | 32 | Pad output enable, 1 = drive |
| pull_dis | output | 32 | Pad pull-disable controls |
| alt_dout | input | 3x32 | Output data of peripherals 0..2 (function 1..3) |
| alt_oe | input | 3x32 | Output enables of peripherals 0..2 |

## Verification
The hardest case to reach from the ports is the read of offset 0x00 while a pad level is crossing the synchronizer. The result then mixes stored bits on output pins with stale or fresh pad bits on input pins. The stimulus splits the bank into output and input halves and changes `pin_in`. It reads after the first sampling edge, expecting the old level, and again after the second, expecting the new one. The function mux is exercised with adjacent pins in all four selector values at once, with distinct peripheral patterns, so a swapped selector bit or peripheral index shows on a specific pin.

// File: rtl/pinbank_pkg.sv
// Shared constants and types for the pin bank controller.
// Assumes byte offsets on a 6-bit address; only the listed offsets are mapped.
package pinbank_pkg;
    localparam int ADDR_W  = 6;
    localparam int ALT_CNT = 3;

    localparam logic [ADDR_W-1:0] OFF_DOUT     = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_DOUT_SET = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_DOUT_CLR = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_PULL     = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_DIR      = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_DIR_SET  = 6'h14;
    localparam logic [ADDR_W-1:0] OFF_DIR_CLR  = 6'h18;
    localparam logic [ADDR_W-1:0] OFF_FSEL_LO  = 6'h20;
    localparam logic [ADDR_W-1:0] OFF_FSEL_HI  = 6'h24;

    // Decoded write strobes, at most one active per cycle
    typedef struct packed {
        logic dout_ld;
        logic dout_set;
        logic dout_clr;
        logic pull_ld;
        logic dir_ld;
        logic dir_set;
        logic dir_clr;
        logic fsel_lo_ld;
        logic fsel_hi_ld;
    } wr_strb_t;
endpackage

// File: rtl/pinbank_setclr.sv
// Register with whole-word load plus masked set and masked clear.
// Assumes the strobes are mutually exclusive; if not, clear beats set beats load.
module pinbank_setclr #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic             set,
    input  logic             clr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);
    // Update the stored word according to the active strobe
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= q & ~wdata;
        else if (set) q <= q | wdata;
        else if (ld)  q <= wdata;
    end

    // R2 / R4
    setbits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set && !clr) |=> ((q & $past(wdata)) == $past(wdata)));

    // R3 / R4
    clrbits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((q & $past(wdata)) == '0));

    // R2 / R3: bits outside the mask do not move
    keepbits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set || clr) |=> ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));
endmodule

// File: rtl/pinbank_sync.sv
// Two-flop synchronizer for each pad input.
// Assumes pad levels are asynchronous and change slowly compared to clk.
module pinbank_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1;
    logic [1:0]       warm;

    // Two sampling stages per bit
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1[i]   <= 1'b0;
                sync_out[i] <= 1'b0;
            end else begin
                stage1[i]   <= async_in[i];
                sync_out[i] <= stage1[i];
            end
        end
    end

    // Count edges since reset so that the latency check starts after the pipe fills
    always_ff @(posedge clk) begin
        if (!rst_n)          warm <= 2'd0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    // R6
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> (sync_out == $past(async_in, 2)));
endmodule

// File: rtl/pinbank_regs.sv
// Register file: write decode, storage and combinational read mux.
// Assumes at most one bus write per cycle; unmapped offsets are ignored.
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_PINS-1:0] bus_wdata,
    input  logic [N_PINS-1:0] pad_sync,
    output logic [N_PINS-1:0] bus_rdata,
    output logic [N_PINS-1:0] dout_q,
    output logic [N_PINS-1:0] dir_q,
    output logic [N_PINS-1:0] pull_q,
    output logic [N_PINS-1:0] fsel_lo_q,
    output logic [N_PINS-1:0] fsel_hi_q
);
    wr_strb_t strb;

    // Decode the write address into one strobe
    always_comb begin
        strb = '0;
        if (bus_wr) begin
            case (bus_addr)
                OFF_DOUT:     strb.dout_ld    = 1'b1;
                OFF_DOUT_SET: strb.dout_set   = 1'b1;
                OFF_DOUT_CLR: strb.dout_clr   = 1'b1;
                OFF_PULL:     strb.pull_ld    = 1'b1;
                OFF_DIR:      strb.dir_ld     = 1'b1;
                OFF_DIR_SET:  strb.dir_set    = 1'b1;
                OFF_DIR_CLR:  strb.dir_clr    = 1'b1;
                OFF_FSEL_LO:  strb.fsel_lo_ld = 1'b1;
                OFF_FSEL_HI:  strb.fsel_hi_ld = 1'b1;
                default:      strb = '0;
            endcase
        end
    end

    pinbank_setclr #(.WIDTH(N_PINS)) u_dout (
        .clk(clk), .rst_n(rst_n), .ld(strb.dout_ld), .set(strb.dout_set),
        .clr(strb.dout_clr), .wdata(bus_wdata), .q(dout_q)
    );

    pinbank_setclr #(.WIDTH(N_PINS)) u_dir (
        .clk(clk), .rst_n(rst_n), .ld(strb.dir_ld), .set(strb.dir_set),
        .clr(strb.dir_clr), .wdata(bus_wdata), .q(dir_q)
    );

    // Plain storage registers: pull-disable and the two selector planes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pull_q    <= '0;
            fsel_lo_q <= '0;
            fsel_hi_q <= '0;
        end else begin
            if (strb.pull_ld)    pull_q    <= bus_wdata;
            if (strb.fsel_lo_ld) fsel_lo_q <= bus_wdata;
            if (strb.fsel_hi_ld) fsel_hi_q <= bus_wdata;
        end
    end

    // Read mux: data offset merges stored outputs with synchronized inputs
    always_comb begin
        case (bus_addr)
            OFF_DOUT:    bus_rdata = (dout_q & dir_q) | (pad_sync & ~dir_q);
            OFF_PULL:    bus_rdata = pull_q;
            OFF_DIR:     bus_rdata = dir_q;
            OFF_FSEL_LO: bus_rdata = fsel_lo_q;
            OFF_FSEL_HI: bus_rdata = fsel_hi_q;
            default:     bus_rdata = '0;
        endcase
    end

    // R8: at most one register written per cycle
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strb));

    // R8: a write to an unmapped offset leaves all storage alone
    unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && strb == '0) |=> ($stable(dout_q) && $stable(dir_q) && $stable(pull_q)
                                    && $stable(fsel_lo_q) && $stable(fsel_hi_q)));
endmodule

// File: rtl/pinbank_mux.sv
// Per-pin output selector between the pin's own registers and three peripherals.
// Assumes function number = {hi plane bit, lo plane bit}.
module pinbank_mux
    import pinbank_pkg::*;
#(
    parameter int N_PINS = 32
) (
    input  logic [N_PINS-1:0]              dout_q,
    input  logic [N_PINS-1:0]              dir_q,
    input  logic [N_PINS-1:0]              fsel_lo_q,
    input  logic [N_PINS-1:0]              fsel_hi_q,
    input  logic [ALT_CNT-1:0][N_PINS-1:0] alt_dout,
    input  logic [ALT_CNT-1:0][N_PINS-1:0] alt_oe,
    output logic [N_PINS-1:0]              pin_out,
    output logic [N_PINS-1:0]              pin_oe
);
    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        logic [1:0] fnum;
        assign fnum = {fsel_hi_q[i], fsel_lo_q[i]};

        // Choose the data/enable source for this pin
        always_comb begin
            case (fnum)
                2'd1:    begin pin_out[i] = alt_dout[0][i]; pin_oe[i] = alt_oe[0][i]; end
                2'd2:    begin pin_out[i] = alt_dout[1][i]; pin_oe[i] = alt_oe[1][i]; end
                2'd3:    begin pin_out[i] = alt_dout[2][i]; pin_oe[i] = alt_oe[2][i]; end
                default: begin pin_out[i] = dout_q[i];      pin_oe[i] = dir_q[i];     end
            endcase
        end
    end
endmodule

// File: rtl/pinbank_gpio.sv
// Top of the pin bank: register file, input synchronizer and output selector.
// Assumes a bus that issues at most one write per cycle and reads combinationally.
module pinbank_gpio
    import pinbank_pkg::*;
#(
    parameter int N_PINS = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_wr,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [N_PINS-1:0]              bus_wdata,
    output logic [N_PINS-1:0]              bus_rdata,
    input  logic [N_PINS-1:0]              pin_in,
    output logic [N_PINS-1:0]              pin_out,
    output logic [N_PINS-1:0]              pin_oe,
    output logic [N_PINS-1:0]              pull_dis,
    input  logic [ALT_CNT-1:0][N_PINS-1:0] alt_dout,
    input  logic [ALT_CNT-1:0][N_PINS-1:0] alt_oe
);
    logic [N_PINS-1:0] pad_sync;
    logic [N_PINS-1:0] dout_q;
    logic [N_PINS-1:0] dir_q;
    logic [N_PINS-1:0] fsel_lo_q;
    logic [N_PINS-1:0] fsel_hi_q;

    pinbank_sync #(.WIDTH(N_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pad_sync)
    );

    pinbank_regs #(.N_PINS(N_PINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .pad_sync(pad_sync), .bus_rdata(bus_rdata),
        .dout_q(dout_q), .dir_q(dir_q), .pull_q(pull_dis),
        .fsel_lo_q(fsel_lo_q), .fsel_hi_q(fsel_hi_q)
    );

    pinbank_mux #(.N_PINS(N_PINS)) u_mux (
        .dout_q(dout_q), .dir_q(dir_q), .fsel_lo_q(fsel_lo_q), .fsel_hi_q(fsel_hi_q),
        .alt_dout(alt_dout), .alt_oe(alt_oe), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // R4: function-0 pins drive exactly when their direction bit is 1
    gpio_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~(fsel_lo_q | fsel_hi_q)) & (pin_oe ^ dir_q)) == '0);

    // R1: one cycle after reset, nothing drives a pad
    reset_idle_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (pin_oe == '0 && pull_dis == '0));
endmodule

// File: tb/sim_pinbank_gpio.sv
module sim_pinbank_gpio;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [5:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [31:0]       pin_in = '0;
    logic [31:0]       pin_out;
    logic [31:0]       pin_oe;
    logic [31:0]       pull_dis;
    logic [2:0][31:0]  alt_dout = '0;
    logic [2:0][31:0]  alt_oe = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pinbank_gpio u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pull_dis(pull_dis),
        .alt_dout(alt_dout), .alt_oe(alt_oe)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        logic [5:0] offs [9] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h18, 6'h20, 6'h24};
        foreach (offs[k]) begin
            rd(offs[k], v);
            check("R1", $sformatf("read %02h after reset", offs[k]), v, 32'h0);
        end
        check("R1", "pin_oe after reset", pin_oe, 32'h0);
        check("R1", "pin_out after reset", pin_out, 32'h0);
        check("R1", "pull_dis after reset", pull_dis, 32'h0);
    endtask

    task automatic t_setclr();
        logic [31:0] v;
        wr(6'h14, 32'hFFFF_FFFF);
        wr(6'h04, 32'hA5A5_0000);
        check("R2", "pin_out after set", pin_out, 32'hA5A5_0000);
        wr(6'h04, 32'h0000_00F0);
        check("R2", "pin_out after second set", pin_out, 32'hA5A5_00F0);
        wr(6'h08, 32'h8001_0030);
        check("R3", "pin_out after clear", pin_out, 32'h25A4_00C0);
        rd(6'h00, v);
        check("R3", "data read of outputs", v, 32'h25A4_00C0);
        rd(6'h04, v);
        check("R8", "set offset reads 0", v, 32'h0);
        rd(6'h08, v);
        check("R8", "clear offset reads 0", v, 32'h0);
    endtask

    task automatic t_dir();
        logic [31:0] v;
        wr(6'h18, 32'h0F0F_0F0F);
        check("R4", "pin_oe after dir clear", pin_oe, 32'hF0F0_F0F0);
        wr(6'h14, 32'h0000_000F);
        check("R4", "pin_oe after dir set", pin_oe, 32'hF0F0_F0FF);
        rd(6'h10, v);
        check("R8", "direction readback", v, 32'hF0F0_F0FF);
        rd(6'h14, v);
        check("R8", "dir set offset reads 0", v, 32'h0);
        rd(6'h18, v);
        check("R8", "dir clear offset reads 0", v, 32'h0);
    endtask

    task automatic t_direct();
        logic [31:0] v;
        wr(6'h10, 32'h0000_FFFF);
        check("R5", "pin_oe after direct dir load", pin_oe, 32'h0000_FFFF);
        wr(6'h00, 32'h1234_5678);
        check("R5", "pin_out after direct data load", pin_out, 32'h1234_5678);
        rd(6'h10, v);
        check("R5", "direction after direct load", v, 32'h0000_FFFF);
    endtask

    task automatic t_sync();
        logic [31:0] v;
        logic [31:0] exp_old;
        logic [31:0] exp_new;
        // outputs low half hold 5678, input high half sees pad
        exp_old = (32'h1234_5678 & 32'h0000_FFFF) | (32'h0 & 32'hFFFF_0000);
        exp_new = (32'h1234_5678 & 32'h0000_FFFF) | (32'hCAFE_BEEF & 32'hFFFF_0000);
        @(negedge clk);
        pin_in = 32'hCAFE_BEEF;
        @(posedge clk); #1;
        v = bus_rdata;
        bus_addr = 6'h00; #1 v = bus_rdata;
        check("R6", "read one edge after pad change", v, exp_old);
        @(posedge clk); #1;
        v = bus_rdata;
        check("R6", "read two edges after pad change", v, exp_new);
        rd(6'h00, v);
        check("R6", "read stays on new level", v, exp_new);
    endtask

    task automatic t_alt();
        logic [31:0] v;
        logic [31:0] lo;
        logic [31:0] hi;
        logic [31:0] eout;
        logic [31:0] eoe;
        lo = 32'h5555_5555;
        hi = 32'h3333_3333;
        alt_dout[0] = 32'hAAAA_0001; alt_oe[0] = 32'h0F0F_0F0F;
        alt_dout[1] = 32'h1357_9BDF; alt_oe[1] = 32'hFF00_FF00;
        alt_dout[2] = 32'hFEDC_BA98; alt_oe[2] = 32'h00FF_00FF;
        wr(6'h20, lo);
        wr(6'h24, hi);
        for (int i = 0; i < 32; i++) begin
            case ({hi[i], lo[i]})
                2'd0: begin eout[i] = pin_dout_ref(i); eoe[i] = pin_dir_ref(i); end
                2'd1: begin eout[i] = alt_dout[0][i]; eoe[i] = alt_oe[0][i]; end
                2'd2: begin eout[i] = alt_dout[1][i]; eoe[i] = alt_oe[1][i]; end
                default: begin eout[i] = alt_dout[2][i]; eoe[i] = alt_oe[2][i]; end
            endcase
        end
        @(negedge clk);
        check("R7", "pin_out with mixed functions", pin_out, eout);
        check("R7", "pin_oe with mixed functions", pin_oe, eoe);
        rd(6'h20, v);
        check("R8", "selector low plane readback", v, lo);
        rd(6'h24, v);
        check("R8", "selector high plane readback", v, hi);
        wr(6'h20, 32'h0);
        wr(6'h24, 32'h0);
        check("R7", "pin_out back in function 0", pin_out, 32'h1234_5678);
    endtask

    function automatic logic pin_dout_ref(int i);
        logic [31:0] d = 32'h1234_5678;
        return d[i];
    endfunction

    function automatic logic pin_dir_ref(int i);
        logic [31:0] d = 32'h0000_FFFF;
        return d[i];
    endfunction

    task automatic t_pull();
        logic [31:0] v;
        wr(6'h0C, 32'hDEAD_BEEF);
        rd(6'h0C, v);
        check("R9", "pull-disable readback", v, 32'hDEAD_BEEF);
        check("R9", "pull_dis output", pull_dis, 32'hDEAD_BEEF);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(6'h1C, 32'hFFFF_FFFF);
        wr(6'h3C, 32'hFFFF_FFFF);
        wr(6'h28, 32'hFFFF_FFFF);
        rd(6'h1C, v);
        check("R8", "unmapped read", v, 32'h0);
        rd(6'h10, v);
        check("R8", "direction after unmapped writes", v, 32'h0000_FFFF);
        rd(6'h20, v);
        check("R8", "selector after unmapped writes", v, 32'h0);
        check("R8", "pin_out after unmapped writes", pin_out, 32'h1234_5678);
        check("R8", "pull_dis after unmapped writes", pull_dis, 32'hDEAD_BEEF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_setclr();
        t_dir();
        t_direct();
        t_sync();
        t_alt();
        t_pull();
        t_unmapped();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule